// File: doc/BRIEF.md
# SPD-Driven DRAM Timing Selector

This block configures a DRAM controller from the serial-presence-detect bytes of a memory module. After a start pulse it fetches nine SPD bytes, one request at a time, over a simple byte-request/response port. It then turns them into three packed configuration bytes: an address-map type, the end address of the first bank in 16 MB units, and a timing byte. The timing byte holds the CAS latency, the row-precharge, RAS-to-CAS and active-to-precharge choices, and the bank-interleave mode.

The serial bus transaction layer lies outside the block. Whatever sits on the response side only has to return the byte stored at the requested SPD address. A field value that the block does not recognise falls back to a fixed default, so the controller never stalls on a malformed module. All three configuration bytes are updated in the same cycle, and that cycle is marked by a one-cycle done strobe.

Top module: `spd_timing_picker`

## Requirements
- R1: While reset is active, and until the first completed run, map_type, bank_end, timing_cfg, done and req_valid are all zero.
- R2: A run reads the SPD addresses 4, 31, 18, 23, 25, 27, 29, 30 and 17 in that order. Each request holds req_valid with a stable req_addr until req_ready. The next request is issued only after rsp_valid has returned the byte for the previous one.
- R3: map_type is 0x60 when the column-address byte (SPD 4) is 10 or 11, 0x40 when it is 9, 0x20 when it is 8, and 0x00 for any other value.
- R4: bank_end holds the bank-density byte (SPD 31) priority-encoded from highest to lowest priority: bit1→0x80, bit0→0x40, bit7→0x20, bit6→0x10, bit5→0x08, bit4→0x04, bit3→0x02. A set bit2, or no flag at all, gives 0x01.
- R5: timing_cfg[5:4] carries the CAS latency as 01 = CAS 2, 10 = CAS 2.5, 11 = CAS 3. When latency flag bit4 (SPD 18) is set, the choice starts at CAS 3. It moves to CAS 2.5 if flag bit3 is set and the CL-0.5 cycle byte (SPD 23) is at most 0x75. It then moves to CAS 2 if flag bit2 is set and the CL-1 cycle byte (SPD 25) is at most 0x75.
- R6: When latency flag bit4 is clear, the choice is CAS 2.5. It becomes CAS 2 if flag bit2 is set and the CL-0.5 cycle byte (SPD 23) is at most 0x75.
- R7: timing_cfg[7] (precharge 3T) is set when SPD 27 exceeds 0x3C. timing_cfg[2] (RAS-to-CAS 3T) is set when SPD 29 exceeds 0x3C.
- R8: timing_cfg[6] (active-to-precharge 6T) is set when SPD 30 exceeds 0x25, and timing_cfg[3] is always zero.
- R9: timing_cfg[1:0] is 10 when the internal-bank byte (SPD 17) is 4, 01 when it is 2, and 00 otherwise.
- R10: done is high for exactly one cycle per run. The three configuration bytes change only in that cycle and take their new values in it.
- R11: A start pulse while a run is in progress has no effect: no extra run and no extra done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a run when the block is idle |
| req_valid | output | 1 | SPD byte request pending |
| req_ready | input | 1 | Request accepted by the responder |
| req_addr | output | 8 | SPD byte address requested |
| rsp_valid | input | 1 | Response byte present |
| rsp_data | input | 8 | SPD byte returned |
| map_type | output | 8 | Address-map type code |
| bank_end | output | 8 | Bank end address, 16 MB units |
| timing_cfg | output | 8 | Packed CAS / tRP / tRAS / tRCD / interleave byte |
| done | output | 1 | One-cycle strobe marking new configuration |

## Verification
The first request is visible on req_valid in the cycle after start is sampled. Every later request appears in the cycle after the previous response is taken. The configuration bytes and done appear together two cycles after the ninth response is accepted: one cycle in the commit state and one in the output registers. The monitor therefore compares the expected items only in the cycle where it sees done high. In every other cycle it checks that the outputs kept their last values. The responder checks each request address against the fixed read order as the request is accepted, and it varies its latency so the handshake is exercised under stalls.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int unsigned SPD_BYTE_W  = 8;
  localparam int unsigned SPD_ADDR_W  = 8;
  localparam int unsigned SPD_NFIELDS = 9;

  // capture slot index for each fetched SPD byte
  localparam int unsigned FI_COLS  = 0;
  localparam int unsigned FI_DENS  = 1;
  localparam int unsigned FI_CASF  = 2;
  localparam int unsigned FI_CYC05 = 3;
  localparam int unsigned FI_CYC1  = 4;
  localparam int unsigned FI_TRP   = 5;
  localparam int unsigned FI_TRCD  = 6;
  localparam int unsigned FI_TRAS  = 7;
  localparam int unsigned FI_NBANK = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    CAS_NONE = 2'b00,
    CAS_20   = 2'b01,
    CAS_25   = 2'b10,
    CAS_30   = 2'b11
  } cas_sel_t;

  typedef struct packed {
    logic [7:0] map_type;
    logic [7:0] bank_end;
    logic [7:0] timing;
  } cfg_set_t;

  // SPD address fetched into each capture slot, in fetch order
  function automatic logic [7:0] slot_addr(input int unsigned slot);
    logic [7:0] a;
    case (slot)
      FI_COLS:  a = 8'd4;
      FI_DENS:  a = 8'd31;
      FI_CASF:  a = 8'd18;
      FI_CYC05: a = 8'd23;
      FI_CYC1:  a = 8'd25;
      FI_TRP:   a = 8'd27;
      FI_TRCD:  a = 8'd29;
      FI_TRAS:  a = 8'd30;
      default:  a = 8'd17;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/spd_rst_sync.sv
module spd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/spd_fetch_seq.sv
module spd_fetch_seq
  import spd_pkg::*;
#(
  parameter int unsigned NFIELDS = SPD_NFIELDS,
  parameter int unsigned AW      = SPD_ADDR_W,
  parameter int unsigned DW      = SPD_BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [AW-1:0]                req_addr,
  input  logic                         rsp_valid,
  input  logic [DW-1:0]                rsp_data,
  output logic [NFIELDS-1:0][DW-1:0]   fields,
  output logic                         commit
);

  localparam int unsigned IDX_W    = (NFIELDS > 1) ? $clog2(NFIELDS) : 1;
  localparam int unsigned LAST_IDX = NFIELDS - 1;

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             take_rsp;
  logic             last_slot;

  assign last_slot = (idx_q == IDX_W'(LAST_IDX));
  assign take_rsp  = (state_q == ST_WAIT) && rsp_valid;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_REQ;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_REQ: begin
        if (req_ready) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          if (last_slot) begin
            state_d = ST_COMMIT;
          end else begin
            state_d = ST_REQ;
            idx_d   = idx_q + 1'b1;
            idx_en  = 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // one capture register per SPD field
  for (genvar g = 0; g < NFIELDS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = take_rsp && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fields[g] <= '0;
      end else if (slot_en) begin
        fields[g] <= rsp_data;
      end
    end
  end

  assign req_valid = (state_q == ST_REQ);
  assign req_addr  = AW'(slot_addr(32'(idx_q)));
  assign commit    = (state_q == ST_COMMIT);

endmodule

// File: rtl/spd_field_decode.sv
module spd_field_decode
  import spd_pkg::*;
#(
  parameter int unsigned  NFIELDS  = SPD_NFIELDS,
  parameter int unsigned  DW       = SPD_BYTE_W,
  parameter logic [DW-1:0] CYC_MAX  = 8'h75,
  parameter logic [DW-1:0] TRP_MAX  = 8'h3C,
  parameter logic [DW-1:0] TRCD_MAX = 8'h3C,
  parameter logic [DW-1:0] TRAS_MAX = 8'h25
) (
  input  logic [NFIELDS-1:0][DW-1:0] fields,
  output cfg_set_t                   cfg
);

  localparam int unsigned NPRIO = 8;

  logic [DW-1:0] cols, dens, casf, cyc05, cyc1, trp, trcd, tras, nbank;
  logic [7:0]    map_code;
  logic [7:0]    dens_code;
  cas_sel_t      cas_pick;
  logic [1:0]    ilv_code;
  logic          trp_slow, trcd_slow, tras_long;

  assign cols  = fields[FI_COLS];
  assign dens  = fields[FI_DENS];
  assign casf  = fields[FI_CASF];
  assign cyc05 = fields[FI_CYC05];
  assign cyc1  = fields[FI_CYC1];
  assign trp   = fields[FI_TRP];
  assign trcd  = fields[FI_TRCD];
  assign tras  = fields[FI_TRAS];
  assign nbank = fields[FI_NBANK];

  // column count to map type
  always_comb begin
    case (cols)
      DW'(10), DW'(11): map_code = 8'h60;
      DW'(9):           map_code = 8'h40;
      DW'(8):           map_code = 8'h20;
      default:          map_code = 8'h00;
    endcase
  end

  // density priority encoder: rank k tests bit (k<2 ? 1-k : 9-k)
  // and yields 1 << (7-k); lowest rank walked first so higher wins
  always_comb begin
    dens_code = 8'h01;
    for (int k = NPRIO - 1; k >= 0; k--) begin
      if (dens[(k < 2) ? (1 - k) : (9 - k)]) begin
        dens_code = 8'h01 << (7 - k);
      end
    end
  end

  // latency walk
  always_comb begin
    if (casf[4]) begin
      cas_pick = CAS_30;
      if (casf[3] && (cyc05 <= CYC_MAX)) begin
        cas_pick = CAS_25;
      end
      if (casf[2] && (cyc1 <= CYC_MAX)) begin
        cas_pick = CAS_20;
      end
    end else begin
      cas_pick = CAS_25;
      if (casf[2] && (cyc05 <= CYC_MAX)) begin
        cas_pick = CAS_20;
      end
    end
  end

  assign trp_slow  = (trp  > TRP_MAX);
  assign trcd_slow = (trcd > TRCD_MAX);
  assign tras_long = (tras > TRAS_MAX);

  always_comb begin
    if (nbank == DW'(4)) begin
      ilv_code = 2'b10;
    end else if (nbank == DW'(2)) begin
      ilv_code = 2'b01;
    end else begin
      ilv_code = 2'b00;
    end
  end

  assign cfg.map_type = map_code;
  assign cfg.bank_end = dens_code;
  assign cfg.timing   = {trp_slow, tras_long, cas_pick, 1'b0, trcd_slow, ilv_code};

endmodule

// File: rtl/spd_cfg_regs.sv
module spd_cfg_regs
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  cfg_set_t   cfg_in,
  output logic [7:0] map_type,
  output logic [7:0] bank_end,
  output logic [7:0] timing_cfg,
  output logic       done
);

  cfg_set_t cfg_q;
  logic     done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (commit) begin
      cfg_q <= cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
    end
  end

  assign map_type   = cfg_q.map_type;
  assign bank_end   = cfg_q.bank_end;
  assign timing_cfg = cfg_q.timing;
  assign done       = done_q;

endmodule

// File: rtl/spd_timing_picker.sv
module spd_timing_picker
  import spd_pkg::*;
#(
  parameter int unsigned NFIELDS    = SPD_NFIELDS,
  parameter int unsigned AW         = SPD_ADDR_W,
  parameter int unsigned DW         = SPD_BYTE_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [7:0]    map_type,
  output logic [7:0]    bank_end,
  output logic [7:0]    timing_cfg,
  output logic          done
);

  logic                       rst_n_int;
  logic [NFIELDS-1:0][DW-1:0] fields;
  logic                       commit;
  cfg_set_t                   cfg_next;

  spd_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  spd_fetch_seq #(.NFIELDS(NFIELDS), .AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .fields    (fields),
    .commit    (commit)
  );

  spd_field_decode #(.NFIELDS(NFIELDS), .DW(DW)) u_dec (
    .fields (fields),
    .cfg    (cfg_next)
  );

  spd_cfg_regs u_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .commit     (commit),
    .cfg_in     (cfg_next),
    .map_type   (map_type),
    .bank_end   (bank_end),
    .timing_cfg (timing_cfg),
    .done       (done)
  );

endmodule

// File: rtl/spd_timing_picker_chk.sv
module spd_timing_picker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_addr,
  input logic [7:0] map_type,
  input logic [7:0] bank_end,
  input logic [7:0] timing_cfg,
  input logic       done
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(map_type) && $stable(bank_end) && $stable(timing_cfg)));

  // R3
  map_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((map_type & 8'h9F) == 8'h00));

  // R4
  dens_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(bank_end) == 1));

  // R5
  cas_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (timing_cfg[5:4] != 2'b00));

  // R8
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !timing_cfg[3]);

endmodule

bind spd_timing_picker spd_timing_picker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .map_type   (map_type),
  .bank_end   (bank_end),
  .timing_cfg (timing_cfg),
  .done       (done)
);

// File: tb/spd_timing_picker_test.sv
`timescale 1ns/1ps
module spd_timing_picker_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_addr;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic [7:0] map_type;
  logic [7:0] bank_end;
  logic [7:0] timing_cfg;
  logic       done;

  always #2.5 clk = ~clk;

  spd_timing_picker uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .map_type   (map_type),
    .bank_end   (bank_end),
    .timing_cfg (timing_cfg),
    .done       (done)
  );

  typedef struct {
    logic [7:0] m;
    logic [7:0] b;
    logic [7:0] t;
  } exp_item_t;

  exp_item_t  exp_q[$];
  logic [7:0] spd_mem [256];
  logic [7:0] read_order [9] = '{8'd4, 8'd31, 8'd18, 8'd23, 8'd25, 8'd27, 8'd29, 8'd30, 8'd17};
  int         n_chk = 0;
  int         n_bad = 0;
  int         req_pos = 0;
  int         dones = 0;
  int         lat = 0;
  bit         mon_on = 1'b0;
  bit         prev_done = 1'b0;
  logic [7:0] last_m = 8'h00;
  logic [7:0] last_b = 8'h00;
  logic [7:0] last_t = 8'h00;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // expected values written from the requirement text
  function automatic logic [7:0] want_map(input logic [7:0] c);
    if (c == 8'd10 || c == 8'd11) return 8'h60;
    if (c == 8'd9) return 8'h40;
    if (c == 8'd8) return 8'h20;
    return 8'h00;
  endfunction

  function automatic logic [7:0] want_bank(input logic [7:0] d);
    if (d[1]) return 8'h80;
    if (d[0]) return 8'h40;
    if (d[7]) return 8'h20;
    if (d[6]) return 8'h10;
    if (d[5]) return 8'h08;
    if (d[4]) return 8'h04;
    if (d[3]) return 8'h02;
    return 8'h01;
  endfunction

  function automatic logic [7:0] want_timing(input logic [7:0] f, input logic [7:0] c05,
                                             input logic [7:0] c1, input logic [7:0] rp,
                                             input logic [7:0] rcd, input logic [7:0] ras,
                                             input logic [7:0] nb);
    logic [1:0] cl;
    logic [1:0] il;
    if (f[4]) begin
      if (f[2] && c1 <= 8'h75) cl = 2'b01;
      else if (f[3] && c05 <= 8'h75) cl = 2'b10;
      else cl = 2'b11;
    end else begin
      cl = (f[2] && c05 <= 8'h75) ? 2'b01 : 2'b10;
    end
    il = (nb == 8'd4) ? 2'b10 : ((nb == 8'd2) ? 2'b01 : 2'b00);
    return {rp > 8'h3C, ras > 8'h25, cl, 1'b0, rcd > 8'h3C, il};
  endfunction

  // SPD responder model
  initial begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && req_valid === 1'b1) begin
        repeat (lat) @(negedge clk);
        if (req_pos < 9) check("R2 read order", req_addr, read_order[req_pos]);
        else check("R2 too many requests", 8'(req_pos), 8'd9);
        req_pos++;
        req_ready = 1'b1;
        rsp_data  = spd_mem[req_addr];
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (done === 1'b1) begin
          if (prev_done) check("R10 done longer than one cycle", 8'd1, 8'd0);
          if (exp_q.size() == 0) begin
            check("R11 unexpected done", 8'd1, 8'd0);
          end else begin
            exp_item_t e;
            e = exp_q.pop_front();
            check("R3 map_type", map_type, e.m);
            check("R4 bank_end", bank_end, e.b);
            check("R5/R6/R7/R8/R9 timing_cfg", timing_cfg, e.t);
          end
          last_m = map_type;
          last_b = bank_end;
          last_t = timing_cfg;
          dones++;
        end else begin
          check("R10 map_type held", map_type, last_m);
          check("R10 bank_end held", bank_end, last_b);
          check("R10 timing_cfg held", timing_cfg, last_t);
        end
        prev_done = (done === 1'b1);
      end
    end
  end

  task automatic run_case(input logic [7:0] cols, input logic [7:0] dens,
                          input logic [7:0] flags, input logic [7:0] c05,
                          input logic [7:0] c1, input logic [7:0] rp,
                          input logic [7:0] rcd, input logic [7:0] ras,
                          input logic [7:0] nb, input int l, input bit extra_start);
    exp_item_t e;
    int target;
    spd_mem[4]  = cols;
    spd_mem[31] = dens;
    spd_mem[18] = flags;
    spd_mem[23] = c05;
    spd_mem[25] = c1;
    spd_mem[27] = rp;
    spd_mem[29] = rcd;
    spd_mem[30] = ras;
    spd_mem[17] = nb;
    e.m = want_map(cols);
    e.b = want_bank(dens);
    e.t = want_timing(flags, c05, c1, rp, rcd, ras, nb);
    exp_q.push_back(e);
    lat     = l;
    req_pos = 0;
    target  = dones + 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1;        // R11: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait (dones == target);
    repeat (3) @(negedge clk);
    check("R2 request count", 8'(req_pos), 8'd9);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual no completion expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) spd_mem[i] = 8'h00;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 map_type in reset", map_type, 8'h00);
    check("R1 bank_end in reset", bank_end, 8'h00);
    check("R1 timing_cfg in reset", timing_cfg, 8'h00);
    check("R1 done in reset", {7'd0, done}, 8'h00);
    check("R1 req_valid in reset", {7'd0, req_valid}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req_valid after release", {7'd0, req_valid}, 8'h00);
    check("R1 timing_cfg after release", timing_cfg, 8'h00);
    mon_on = 1'b1;

    // R5 bit4 set, CL-1 fast: CAS 2; R7 rcd slow; R8 6T; R9 four banks; R4 bit1 wins
    run_case(8'd10, 8'h22, 8'h1C, 8'h75, 8'h75, 8'h3C, 8'h3D, 8'h26, 8'd4, 0, 1'b0);
    // R5 CAS 2.5 (CL-1 too slow); R7 rp slow; R9 two banks; R11 extra start
    run_case(8'd9, 8'h40, 8'h18, 8'h75, 8'h76, 8'h50, 8'h20, 8'h25, 8'd2, 2, 1'b1);
    // R5 only bit4: CAS 3; R4 bit2 -> 0x01; R9 other count
    run_case(8'd8, 8'h04, 8'h10, 8'h10, 8'h10, 8'h3D, 8'h3C, 8'h10, 8'd8, 1, 1'b0);
    // R6 bit4 clear -> CAS 2; R3 unknown columns; R4 no flag
    run_case(8'd12, 8'h00, 8'h0C, 8'h70, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'd0, 0, 1'b0);
    // R6 bit2 clear stays CAS 2.5; R4 bit0 over bit7; R3 eleven columns
    run_case(8'd11, 8'h81, 8'h08, 8'h70, 8'h70, 8'h3C, 8'h3C, 8'h25, 8'd4, 3, 1'b0);
    // R5 CL-0.5 too slow but CL-1 fast -> CAS 2; R3 seven columns
    run_case(8'd7, 8'h30, 8'h1C, 8'h80, 8'h70, 8'h41, 8'h41, 8'h30, 8'd2, 1, 1'b0);
    // R6 CL-0.5 slow -> CAS 2.5; R4 bit7 -> 0x20
    run_case(8'd9, 8'h88, 8'h04, 8'h76, 8'h00, 8'h01, 8'h01, 8'h01, 8'd1, 0, 1'b0);

    repeat (30) @(negedge clk);
    // R11: no extra run was started by the start pulse during a run
    check("R11 done count", 8'(dones), 8'd7);
    check("R11 no pending request", {7'd0, req_valid}, 8'h00);
    check("R11 expected queue drained", 8'(exp_q.size()), 8'd0);
    summary();
    $finish;
  end

endmodule